// File: doc/BRIEF.md
# Critical Path Prediction Table

This block guesses, for each instruction, whether it sits on the chain of dependent operations that sets a program's run time. The scheduler presents an instruction address on the lookup side. One clock later the table answers with a single bit, and the scheduler uses that bit to send the instruction to a fast execution unit or to a slow, low-power one. When an instruction retires, the logic that measured its real criticality sends the address and the observed outcome to the update side. The table then moves that instruction's confidence counter one step toward the outcome.

Storage is a direct-mapped array of 4096 three-bit saturating counters. The array is selected by address bits [13:2] and has no tags, so instructions whose addresses differ only outside that field share one counter. The answer is "critical" only when the counter is above a fixed threshold of 5. The top bit of the counter is not used as the prediction.

The control is a two-state machine:

- **CLEAR** is entered on reset. In this state the machine writes zero into every entry, one entry per cycle.
- **RUN** is normal operation, with lookups and updates enabled.

There are two transitions:

- **CLEAR→RUN** happens once the last entry has been written.
- **any→CLEAR** happens on reset.

Top module: `crit_pred_table`

## Requirements
- R1: The entry is chosen by pc[13:2]. Address bits [1:0] and bits above 13 do not affect the selection, so addresses that agree in [13:2] share one counter.
- R2: An update in RUN with upd_critical=1 raises the selected counter by one.
- R3: An update in RUN with upd_critical=0 lowers the selected counter by one.
- R4: A counter at 7 stays at 7 on a critical update and does not wrap to 0.
- R5: A counter at 0 stays at 0 on a non-critical update and does not wrap to 7.
- R6: pred_critical is 1 only for counter values 6 and 7. It is 0 for values 0 to 5.
- R7: After reset the table stays in CLEAR, with table_ready=0, for exactly 4096 cycles. During CLEAR, predictions are 0 and updates are dropped. On entering RUN, every counter holds 0 and table_ready stays 1 until the next reset.
- R8: pred_critical is registered. It reflects the lookup presented in the previous cycle and is 0 when lookup_valid was 0 in that cycle.
- R9: When a lookup and an update select the same entry in the same cycle, the lookup answers from the value before the update. The update still takes effect.
- R10: A lookup and an update that select different entries in the same cycle do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; starts CLEAR |
| lookup_valid | input | 1 | A lookup is requested this cycle |
| lookup_pc | input | 32 | Address of the instruction being looked up |
| upd_valid | input | 1 | An update is presented this cycle |
| upd_pc | input | 32 | Address of the retired instruction |
| upd_critical | input | 1 | Observed outcome: 1 = critical, 0 = not critical |
| pred_critical | output | 1 | Prediction for the previous cycle's lookup |
| table_ready | output | 1 | High once the array has been cleared (RUN state) |

## Verification
A lookup and an update can land on one entry in the same clock, and this is where a wrong read/write ordering would show. The bench trains an entry to exactly 5, then issues a lookup of that entry together with a critical update of it. It expects a 0 answer, which is the pre-update value, and then expects a 1 on a follow-up lookup. The bench repeats this from 6 with a non-critical update, expecting 1 and then 0. A separate test pairs a lookup and an update on different entries in one cycle to show that they stay independent.

// File: rtl/crit_pred_pkg.sv
package crit_pred_pkg;
    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } tbl_state_t;
endpackage

// File: rtl/crit_pc_index.sv
module crit_pc_index #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 12,
    parameter int IDX_LSB = 2
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    // Bits outside the index field are discarded on purpose (no tag).
    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:IDX_LSB+IDX_W], pc[IDX_LSB-1:0]};
    assign idx = pc[IDX_LSB +: IDX_W];
endmodule

// File: rtl/crit_ctr_step.sv
module crit_ctr_step #(
    parameter int CTR_W = 3
) (
    input  logic [CTR_W-1:0] cur,
    input  logic             up,
    output logic [CTR_W-1:0] nxt
);
    localparam logic [CTR_W-1:0] CMAX = '1;
    localparam logic [CTR_W-1:0] CMIN = '0;

    always_comb begin
        if (up)
            nxt = (cur == CMAX) ? CMAX : cur + 1'b1;
        else
            nxt = (cur == CMIN) ? CMIN : cur - 1'b1;
    end
endmodule

// File: rtl/crit_ctr_array.sv
module crit_ctr_array #(
    parameter int IDX_W = 12,
    parameter int CTR_W = 3
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CTR_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [CTR_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [CTR_W-1:0] rd_b_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [CTR_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    assign rd_a_data = mem[rd_a_idx];
    assign rd_b_data = mem[rd_b_idx];
endmodule

// File: rtl/crit_pred_table.sv
module crit_pred_table
    import crit_pred_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 12,
    parameter int IDX_LSB = 2,
    parameter int CTR_W   = 3,
    parameter int THRESH  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lookup_valid,
    input  logic [PC_W-1:0] lookup_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_critical,
    output logic            pred_critical,
    output logic            table_ready
);
    localparam logic [IDX_W-1:0] LAST_IDX = '1;
    localparam logic [CTR_W-1:0] THR_V    = CTR_W'(THRESH);

    tbl_state_t       state_q, state_d;
    logic [IDX_W-1:0] clr_q, clr_d;
    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [CTR_W-1:0] lk_val, upd_cur, upd_nxt;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [CTR_W-1:0] wr_data;
    logic             pred_q;

    crit_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_lk_hash (
        .pc(lookup_pc), .idx(lk_idx)
    );
    crit_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_up_hash (
        .pc(upd_pc), .idx(up_idx)
    );
    crit_ctr_step #(.CTR_W(CTR_W)) u_step (
        .cur(upd_cur), .up(upd_critical), .nxt(upd_nxt)
    );
    crit_ctr_array #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_array (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_a_idx(lk_idx), .rd_a_data(lk_val),
        .rd_b_idx(up_idx), .rd_b_data(upd_cur)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEAR;
            clr_q   <= '0;
        end else begin
            state_q <= state_d;
            clr_q   <= clr_d;
        end
    end

    // Next state and array write port
    always_comb begin
        state_d = state_q;
        clr_d   = clr_q;
        wr_en   = 1'b0;
        wr_idx  = up_idx;
        wr_data = upd_nxt;
        unique case (state_q)
            ST_CLEAR: begin
                wr_en   = 1'b1;
                wr_idx  = clr_q;
                wr_data = '0;
                clr_d   = clr_q + 1'b1;
                if (clr_q == LAST_IDX)
                    state_d = ST_RUN;
            end
            ST_RUN: begin
                wr_en = upd_valid;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    // Registered prediction (old value on same-entry update)
    always_ff @(posedge clk) begin
        if (rst)
            pred_q <= 1'b0;
        else
            pred_q <= (state_q == ST_RUN) && lookup_valid && (lk_val > THR_V);
    end

    assign pred_critical = pred_q;
    assign table_ready   = (state_q == ST_RUN);
endmodule

// File: rtl/crit_pred_table_chk.sv
module crit_pred_table_chk #(
    parameter int CTR_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             lookup_valid,
    input logic             upd_valid,
    input logic             upd_critical,
    input logic             pred_critical,
    input logic             table_ready,
    input logic [CTR_W-1:0] upd_old,
    input logic [CTR_W-1:0] upd_new
);
    localparam logic [CTR_W-1:0] CMAX = '1;
    localparam logic [CTR_W-1:0] CMIN = '0;

    logic run_upd;
    assign run_upd = table_ready && upd_valid;

    a_r7_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        table_ready |=> table_ready);

    a_r7_quiet_clearing: assert property (@(posedge clk) disable iff (rst)
        !table_ready |=> !pred_critical);

    a_r8_pred_needs_lookup: assert property (@(posedge clk) disable iff (rst)
        pred_critical |-> $past(lookup_valid));

    a_r4_ceiling: assert property (@(posedge clk) disable iff (rst)
        (run_upd && upd_critical && upd_old == CMAX) |-> upd_new == CMAX);

    a_r5_floor: assert property (@(posedge clk) disable iff (rst)
        (run_upd && !upd_critical && upd_old == CMIN) |-> upd_new == CMIN);

    a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
        (run_upd && upd_critical && upd_old != CMAX) |-> upd_new == CTR_W'(upd_old + 1'b1));

    a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
        (run_upd && !upd_critical && upd_old != CMIN) |-> upd_new == CTR_W'(upd_old - 1'b1));
endmodule

bind crit_pred_table crit_pred_table_chk #(.CTR_W(CTR_W)) u_chk (
    .clk(clk), .rst(rst), .lookup_valid(lookup_valid), .upd_valid(upd_valid),
    .upd_critical(upd_critical), .pred_critical(pred_critical),
    .table_ready(table_ready), .upd_old(upd_cur), .upd_new(upd_nxt)
);

// File: tb/crit_pred_table_test.sv
module crit_pred_table_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lookup_valid = 1'b0;
    logic [31:0] lookup_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_critical = 1'b0;
    logic        pred_critical;
    logic        table_ready;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    crit_pred_table uut (
        .clk(clk), .rst(rst), .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_critical(upd_critical),
        .pred_critical(pred_critical), .table_ready(table_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, edge, back at negedge for sampling.
    task automatic step(input logic lv, input logic [31:0] lpc,
                        input logic uv, input logic [31:0] upc, input logic uc);
        lookup_valid = lv; lookup_pc = lpc;
        upd_valid = uv; upd_pc = upc; upd_critical = uc;
        @(posedge clk);
        @(negedge clk);
        lookup_valid = 1'b0; upd_valid = 1'b0;
    endtask

    task automatic train(input logic [31:0] pc, input logic c, input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b1, pc, c);
    endtask

    task automatic lookup(input logic [31:0] pc, output logic p);
        step(1'b1, pc, 1'b0, '0, 1'b0);
        p = pred_critical;
    endtask

    task automatic t_reset_clear();
        int edges;
        logic p;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 ready low in reset", table_ready, 0);
        rst = 1'b0;
        edges = 0;
        // updates during CLEAR must be dropped; lookups answer 0
        for (int i = 0; i < 7; i++) begin
            step(1'b1, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1);
            edges++;
            check("R7 no prediction during clear", pred_critical, 0);
        end
        while (!table_ready && edges < 5000) begin
            @(negedge clk);
            edges++;
        end
        check("R7 clear length", edges, 4096);
        lookup(32'h0000_0100, p);
        check("R7 update during clear dropped", p, 0);
    endtask

    task automatic t_threshold();
        logic p;
        logic [31:0] pc = 32'h0000_0200;
        train(pc, 1'b1, 5);
        lookup(pc, p);
        check("R6 value 5 not critical (R2)", p, 0);
        train(pc, 1'b1, 1);
        lookup(pc, p);
        check("R6 value 6 critical (R2)", p, 1);
    endtask

    task automatic t_ceiling();
        logic p;
        logic [31:0] pc = 32'h0000_0200;
        train(pc, 1'b1, 3);          // 6 -> 7, saturating
        train(pc, 1'b0, 2);          // 7 -> 5
        lookup(pc, p);
        check("R4 saturate at 7 then R3 down to 5", p, 0);
        train(pc, 1'b1, 1);
        lookup(pc, p);
        check("R4 back to 6", p, 1);
    endtask

    task automatic t_floor();
        logic p;
        logic [31:0] pc = 32'h0000_0300;
        train(pc, 1'b0, 3);          // stays 0
        train(pc, 1'b1, 5);          // 5
        lookup(pc, p);
        check("R5 floor holds, value 5", p, 0);
        train(pc, 1'b1, 1);
        lookup(pc, p);
        check("R5 value 6 after floor", p, 1);
        train(pc, 1'b0, 1);
        lookup(pc, p);
        check("R3 decrement 6 to 5", p, 0);
    endtask

    task automatic t_alias();
        logic p;
        logic [31:0] pc = 32'h0000_1000;
        train(pc, 1'b1, 6);
        lookup(pc | 32'h3, p);
        check("R1 low two bits ignored", p, 1);
        lookup(pc + 32'h0000_4000, p);
        check("R1 bit 14 aliases", p, 1);
        lookup(pc + 32'h4, p);
        check("R1 neighbour entry separate", p, 0);
    endtask

    task automatic t_no_lookup();
        step(1'b0, 32'h0000_1000, 1'b0, '0, 1'b0);
        check("R8 no lookup gives 0", pred_critical, 0);
    endtask

    task automatic t_same_entry();
        logic p;
        logic [31:0] pc = 32'h0000_2000;
        train(pc, 1'b1, 5);
        step(1'b1, pc, 1'b1, pc, 1'b1);
        check("R9 lookup sees old value 5", pred_critical, 0);
        lookup(pc, p);
        check("R9 update applied, now 6", p, 1);
        step(1'b1, pc, 1'b1, pc, 1'b0);
        check("R9 lookup sees old value 6", pred_critical, 1);
        lookup(pc, p);
        check("R9 update applied, now 5", p, 0);
    endtask

    task automatic t_two_entries();
        logic p;
        logic [31:0] pa = 32'h0000_3000;
        logic [31:0] pb = 32'h0000_3004;
        train(pa, 1'b1, 6);
        step(1'b1, pa, 1'b1, pb, 1'b1);
        check("R10 lookup unaffected by other update", pred_critical, 1);
        train(pb, 1'b1, 4);
        lookup(pb, p);
        check("R10 other entry at 5", p, 0);
        lookup(pa, p);
        check("R10 first entry kept 6", p, 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got %0d cycles expected below 100000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        t_reset_clear();
        t_threshold();
        t_ceiling();
        t_floor();
        t_alias();
        t_no_lookup();
        t_same_entry();
        t_two_entries();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule